// File: doc/BRIEF.md
# Platform Interrupt Router

This block collects level-sensitive interrupt lines from many devices and routes them to several processor targets. Software programs a priority for every source, an enable mask and a priority threshold for every target, all through a small word-addressed register port. A source that is pending, enabled for a target and strictly above that target's threshold raises the target's request output. One pending source can raise several targets at once.

A target services an interrupt by reading its claim register. The read returns the ID of the best eligible source and moves that source into service, so any other target that reads its own claim register afterwards no longer sees it. When the handler has finished, the target writes the same ID to its complete register, which re-opens the source for new requests.

Each source is tracked by a three-state machine: `GW_IDLE` (waiting for the line), `GW_PEND` (request latched), `GW_SERV` (claimed, waiting for completion). The named transitions are *latch* (`GW_IDLE` to `GW_PEND` while the line is high), *claim* (`GW_PEND` to `GW_SERV` on a claim read that returns this ID) and *complete* (`GW_SERV` to `GW_IDLE` on a complete write of this ID). Every other case keeps the current state.

Top module: `irq_router`

## Requirements
- R1: After reset every request output is low, every priority, threshold and enable bit reads 0, and a claim read returns 0.
- R2: Address bits [11:8] select a region and bits [7:0] an index. Region 0 holds the 3-bit priority of source ID index (IDs 1 to NSRC); only data bits [2:0] are stored and read back.
- R3: Region 1 holds the enable mask of target index: data bit i enables source i. Bit 0 always reads 0. Region 2 holds the 3-bit threshold of target index.
- R4: A pending source enabled for a target raises that target's request only when its priority is strictly greater than the target's threshold. For example, source 20 with priority 2 reaches targets with thresholds 0 and 1 but not 2 or 3.
- R5: A single pending source raises the request of every eligible target in the same cycle.
- R6: A read of region 3 at a target index (claim) returns the ID of the highest-priority eligible source for that target. Ties go to the lowest ID, and 0 means nothing is eligible.
- R7: A claim that returns a non-zero ID takes that source out of pending, so a later claim by any target does not return that ID and the requests it caused fall.
- R8: A claimed source cannot become pending again, whatever its line does, until its ID is written to region 3 of any target (complete). After that it re-latches one cycle later if its line is still high.
- R9: A source with priority 0 never raises a request and is never returned by a claim.
- R10: Once latched, a pending request stays pending after its line falls, until it is claimed.
- R11: A complete write whose ID is not in service has no effect.
- R12: Raising a target's threshold masks every source whose priority is at or below the new value; lowering it again unmasks them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NSRC | Level interrupt lines; bit i is source ID i |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe; a read in region 3 performs a claim |
| reg_addr_i | input | 12 | Region in [11:8], index in [7:0] |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, valid in the cycle of the read |
| irq_o | output | NTGT | Per-target interrupt request |

## Verification
The bench builds the block with its defaults: 31 sources, 4 targets and 32-bit data. This gives source ID 20 a real line, so the threshold example can be run across four targets whose thresholds are 0 to 3. Four targets also show several requests rising in the same cycle and a second claimer finding nothing left. The 3-bit priority width lets the bench test the truncation of a wide write and set up equal-priority ties for the lowest-ID rule.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_SERV = 2'd2
    } gw_state_e;

    localparam logic [3:0] RG_PRIO  = 4'h0;
    localparam logic [3:0] RG_ENAB  = 4'h1;
    localparam logic [3:0] RG_THRS  = 4'h2;
    localparam logic [3:0] RG_CLAIM = 4'h3;

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway
    import irq_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pend_o
);

    gw_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GW_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        pend_o = 1'b0;
        unique case (st_q)
            GW_IDLE: if (line_i) st_d = GW_PEND;
            GW_PEND: begin
                pend_o = 1'b1;
                if (claim_i) st_d = GW_SERV;
            end
            GW_SERV: if (done_i) st_d = GW_IDLE;
            default: st_d = GW_IDLE;
        endcase
    end

    // a claim must only ever hit a pending source
    assert_claim_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |-> st_q == GW_PEND);

    // in service holds until completion
    assert_serv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GW_SERV && !done_i) |=> st_q == GW_SERV);

    // latched request survives line drop
    assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GW_PEND && !claim_i) |=> st_q == GW_PEND);

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_router_pkg::*;
#(
    parameter int NSRC = 31,
    parameter int NTGT = 4,
    parameter int PW   = 3,
    parameter int DW   = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [3:0]    region_i,
    input  logic [7:0]    idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic [PW-1:0] prio_o [NSRC+1],
    output logic [NSRC:0] enab_o [NTGT],
    output logic [PW-1:0] thr_o  [NTGT]
);

    assign prio_o[0] = '0;

    for (genvar i = 1; i <= NSRC; i++) begin : g_prio
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_o[i] <= '0;
            else if (we_i && region_i == RG_PRIO && idx_i == 8'(i))
                prio_o[i] <= wdata_i[PW-1:0];
        end
    end

    for (genvar t = 0; t < NTGT; t++) begin : g_tgt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                enab_o[t] <= '0;
                thr_o[t]  <= '0;
            end else if (we_i && idx_i == 8'(t)) begin
                if (region_i == RG_ENAB) enab_o[t] <= {wdata_i[NSRC:1], 1'b0};
                if (region_i == RG_THRS) thr_o[t]  <= wdata_i[PW-1:0];
            end
        end

        assert_enab_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
            enab_o[t][0] == 1'b0);
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC = 31,
    parameter int PW   = 3,
    parameter int IW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NSRC:0] pend_i,
    input  logic [NSRC:0] enab_i,
    input  logic [PW-1:0] prio_i [NSRC+1],
    input  logic [PW-1:0] thr_i,
    output logic [IW-1:0] best_o,
    output logic          req_o
);

    logic [PW-1:0] best_prio;
    logic [PW-1:0] chk_prio;

    always_comb begin
        best_o    = '0;
        best_prio = thr_i;
        for (int i = 0; i <= NSRC; i++) begin
            if (pend_i[i] && enab_i[i] && prio_i[i] > best_prio) begin
                best_o    = IW'(i);
                best_prio = prio_i[i];
            end
        end
        req_o = best_o != '0;
    end

    // independent look-up of the winner's priority for the checks
    always_comb begin
        chk_prio = '0;
        for (int i = 0; i <= NSRC; i++)
            if (best_o == IW'(i)) chk_prio = prio_i[i];
    end

    assert_above_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> chk_prio > thr_i);

    assert_prio_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> chk_prio != '0);

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NSRC = 31,
    parameter int NTGT = 4,
    parameter int PW   = 3,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC:1]   irq_i,
    input  logic            reg_we_i,
    input  logic            reg_re_i,
    input  logic [11:0]     reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    output logic [NTGT-1:0] irq_o
);

    localparam int IW = $clog2(NSRC + 1);

    logic [3:0]    region;
    logic [7:0]    idx;
    logic [PW-1:0] prio  [NSRC+1];
    logic [NSRC:0] enab  [NTGT];
    logic [PW-1:0] thr   [NTGT];
    logic [IW-1:0] best  [NTGT];
    logic [NSRC:0] pend_vec;
    logic [NSRC:0] claim_vec;
    logic [NSRC:0] done_vec;
    logic          tgt_ok;
    logic [IW-1:0] claim_id;
    logic          claim_fire;

    assign region = reg_addr_i[11:8];
    assign idx    = reg_addr_i[7:0];

    irq_cfg_regs #(.NSRC(NSRC), .NTGT(NTGT), .PW(PW), .DW(DW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we_i),
        .region_i (region),
        .idx_i    (idx),
        .wdata_i  (reg_wdata_i),
        .prio_o   (prio),
        .enab_o   (enab),
        .thr_o    (thr)
    );

    assign pend_vec[0] = 1'b0;

    for (genvar i = 1; i <= NSRC; i++) begin : g_src
        irq_gateway u_gw (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (irq_i[i]),
            .claim_i (claim_vec[i]),
            .done_i  (done_vec[i]),
            .pend_o  (pend_vec[i])
        );
    end

    for (genvar t = 0; t < NTGT; t++) begin : g_arb
        irq_arbiter #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .pend_i (pend_vec),
            .enab_i (enab[t]),
            .prio_i (prio),
            .thr_i  (thr[t]),
            .best_o (best[t]),
            .req_o  (irq_o[t])
        );
    end

    // target decode for the claim/complete region
    always_comb begin
        tgt_ok   = 1'b0;
        claim_id = '0;
        for (int t = 0; t < NTGT; t++) begin
            if (idx == 8'(t)) begin
                tgt_ok   = 1'b1;
                claim_id = best[t];
            end
        end
    end

    assign claim_fire = reg_re_i && region == RG_CLAIM && tgt_ok && claim_id != '0;

    always_comb begin
        for (int i = 0; i <= NSRC; i++) begin
            claim_vec[i] = claim_fire && claim_id == IW'(i);
            done_vec[i]  = reg_we_i && region == RG_CLAIM && tgt_ok
                           && reg_wdata_i == DW'(i);
        end
    end

    // read multiplexer
    always_comb begin
        reg_rdata_o = '0;
        unique case (region)
            RG_PRIO: begin
                for (int i = 1; i <= NSRC; i++)
                    if (idx == 8'(i)) reg_rdata_o[PW-1:0] = prio[i];
            end
            RG_ENAB: begin
                for (int t = 0; t < NTGT; t++)
                    if (idx == 8'(t)) reg_rdata_o[NSRC:0] = enab[t];
            end
            RG_THRS: begin
                for (int t = 0; t < NTGT; t++)
                    if (idx == 8'(t)) reg_rdata_o[PW-1:0] = thr[t];
            end
            RG_CLAIM: reg_rdata_o[IW-1:0] = claim_id;
            default: reg_rdata_o = '0;
        endcase
    end

    // a claimed ID is gone for every target in the following cycle
    for (genvar t = 0; t < NTGT; t++) begin : g_chk
        assert_first_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            claim_fire |=> best[t] != $past(claim_id));
    end

    assert_claim_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec));

endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;

    localparam int CLK_P = 10;
    localparam int NSRC  = 31;
    localparam int NTGT  = 4;
    localparam int DW    = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC:1]   irq_i = '0;
    logic            reg_we_i = 1'b0;
    logic            reg_re_i = 1'b0;
    logic [11:0]     reg_addr_i = '0;
    logic [DW-1:0]   reg_wdata_i = '0;
    logic [DW-1:0]   reg_rdata_o;
    logic [NTGT-1:0] irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_router #(.NSRC(NSRC), .NTGT(NTGT), .PW(3), .DW(DW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq_i),
        .reg_we_i    (reg_we_i),
        .reg_re_i    (reg_re_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] rg, input int ix, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we_i    = 1'b1;
        reg_addr_i  = {rg, 8'(ix)};
        reg_wdata_i = d;
        @(negedge clk);
        reg_we_i    = 1'b0;
        reg_wdata_i = '0;
    endtask

    task automatic rd(input logic [3:0] rg, input int ix, output logic [DW-1:0] d);
        @(negedge clk);
        reg_re_i   = 1'b1;
        reg_addr_i = {rg, 8'(ix)};
        #1;
        d = reg_rdata_o;
        @(negedge clk);
        reg_re_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        check("R1 irq after reset", DW'(irq_o), '0);
        rd(4'h0, 5, d);  check("R1 prio reset", d, '0);
        rd(4'h1, 2, d);  check("R1 enable reset", d, '0);
        rd(4'h2, 3, d);  check("R1 thr reset", d, '0);
        rd(4'h3, 0, d);  check("R1 claim reset", d, '0);
    endtask

    task automatic t_regs();
        logic [DW-1:0] d;
        wr(4'h0, 3, 32'd5);          rd(4'h0, 3, d); check("R2 prio readback", d, 32'd5);
        wr(4'h0, 3, 32'hFFFF_FFFF);  rd(4'h0, 3, d); check("R2 prio 3-bit", d, 32'd7);
        wr(4'h0, 3, 32'd0);
        wr(4'h1, 1, 32'hFFFF_FFFF);  rd(4'h1, 1, d); check("R3 enable bit0 zero", d, 32'hFFFF_FFFE);
        wr(4'h1, 1, 32'd0);
        wr(4'h2, 2, 32'hA);          rd(4'h2, 2, d); check("R3 thr 3-bit", d, 32'd2);
        wr(4'h2, 2, 32'd0);
    endtask

    task automatic t_example();
        logic [DW-1:0] d;
        for (int t = 0; t < NTGT; t++) begin
            wr(4'h2, t, DW'(t));
            wr(4'h1, t, 32'h1 << 20);
        end
        wr(4'h0, 20, 32'd2);
        @(negedge clk); irq_i[20] = 1'b1;
        @(negedge clk);
        check("R4 R5 threshold example", DW'(irq_o), 32'b0011);
        rd(4'h3, 1, d); check("R7 first claimer gets 20", d, 32'd20);
        check("R7 requests drop after claim", DW'(irq_o), '0);
        rd(4'h3, 0, d); check("R7 second claimer gets 0", d, '0);
        irq_i[20] = 1'b0;
        wr(4'h3, 1, 32'd20);
        idle(2);
        check("R8 idle after complete with line low", DW'(irq_o), '0);
        for (int t = 0; t < NTGT; t++) begin
            wr(4'h2, t, 32'd0);
            wr(4'h1, t, 32'd0);
        end
        wr(4'h0, 20, 32'd0);
    endtask

    task automatic t_order();
        logic [DW-1:0] d;
        wr(4'h1, 0, (32'h1 << 5) | (32'h1 << 6) | (32'h1 << 9));
        wr(4'h0, 5, 32'd3);
        wr(4'h0, 6, 32'd6);
        wr(4'h0, 9, 32'd6);
        @(negedge clk); irq_i[5] = 1'b1; irq_i[6] = 1'b1; irq_i[9] = 1'b1;
        @(negedge clk); irq_i = '0;
        rd(4'h3, 0, d); check("R6 tie lowest id", d, 32'd6);
        rd(4'h3, 0, d); check("R6 next equal prio", d, 32'd9);
        rd(4'h3, 0, d); check("R6 lower prio last", d, 32'd5);
        rd(4'h3, 0, d); check("R6 none left", d, 32'd0);
        wr(4'h3, 0, 32'd5); wr(4'h3, 0, 32'd6); wr(4'h3, 0, 32'd9);
        wr(4'h1, 0, 32'd0);
    endtask

    task automatic t_service();
        logic [DW-1:0] d;
        wr(4'h1, 2, 32'h1 << 2);
        wr(4'h0, 2, 32'd1);
        @(negedge clk); irq_i[2] = 1'b1;
        @(negedge clk);
        rd(4'h3, 2, d); check("R8 claim source 2", d, 32'd2);
        idle(3);
        check("R8 no re-pend in service", DW'(irq_o[2]), '0);
        wr(4'h3, 2, 32'd3);
        idle(2);
        check("R11 wrong complete ignored", DW'(irq_o[2]), '0);
        rd(4'h3, 2, d); check("R11 claim still empty", d, '0);
        wr(4'h3, 2, 32'd2);
        @(negedge clk);
        check("R8 re-latch after complete", DW'(irq_o[2]), 32'd1);
        rd(4'h3, 2, d); check("R8 reclaim", d, 32'd2);
        irq_i[2] = 1'b0;
        wr(4'h3, 2, 32'd2);
        wr(4'h1, 2, 32'd0);
    endtask

    task automatic t_prio0();
        logic [DW-1:0] d;
        wr(4'h1, 0, 32'h1 << 7);
        @(negedge clk); irq_i[7] = 1'b1;
        idle(2);
        check("R9 prio 0 no request", DW'(irq_o[0]), '0);
        rd(4'h3, 0, d); check("R9 prio 0 not claimed", d, '0);
        wr(4'h0, 7, 32'd4);
        check("R9 held request appears with prio", DW'(irq_o[0]), 32'd1);
        rd(4'h3, 0, d);
        irq_i[7] = 1'b0;
        wr(4'h3, 0, 32'd7);
        wr(4'h0, 7, 32'd0);
        wr(4'h1, 0, 32'd0);
    endtask

    task automatic t_level();
        logic [DW-1:0] d;
        wr(4'h1, 3, 32'h1 << 11);
        wr(4'h0, 11, 32'd3);
        @(negedge clk); irq_i[11] = 1'b1;
        @(negedge clk); irq_i[11] = 1'b0;
        idle(3);
        check("R10 pending held after pulse", DW'(irq_o[3]), 32'd1);
        rd(4'h3, 3, d); check("R10 claim pulsed source", d, 32'd11);
        wr(4'h3, 3, 32'd11);
        idle(2);
        check("R10 no re-latch with line low", DW'(irq_o[3]), '0);
        wr(4'h1, 3, 32'd0);
    endtask

    task automatic t_mask();
        logic [DW-1:0] d;
        wr(4'h1, 0, 32'h1 << 12);
        wr(4'h0, 12, 32'd4);
        @(negedge clk); irq_i[12] = 1'b1;
        @(negedge clk);
        check("R12 request below mask", DW'(irq_o[0]), 32'd1);
        wr(4'h2, 0, 32'd4);
        check("R12 masked at equal threshold", DW'(irq_o[0]), '0);
        rd(4'h3, 0, d); check("R12 masked claim empty", d, '0);
        wr(4'h2, 0, 32'd3);
        check("R12 unmasked", DW'(irq_o[0]), 32'd1);
        rd(4'h3, 0, d); check("R12 claim after unmask", d, 32'd12);
        irq_i[12] = 1'b0;
        wr(4'h3, 0, 32'd12);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_regs();
        t_example();
        t_order();
        t_service();
        t_prio0();
        t_level();
        t_mask();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 100000; k++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule